// File: doc/BRIEF.md
# Legacy Bus Interrupt Aggregator

This block gathers eleven edge-triggered interrupt lines from a legacy expansion bus and condenses them into one summary interrupt for the processor. The legacy IRQ numbers it serves are scattered. It packs them into a dense 11-bit field. Each line passes through a two-flop synchroniser. A rising edge then latches a sticky status bit. The status bits are ANDed with an enable mask to form the pending set. The summary output is a registered OR of that pending set.

Alongside the summary line, the block reports which source software should service next. It gives both the packed bit index and the legacy IRQ number that bit stands for. Priority follows the packed bit order, not the IRQ number order. A byte-wide register port gives access to two status bytes, two mask bytes and a fixed version byte. Software acknowledges a source by writing a one to its status bit.

Top module: `isa_irq_aggregator`

## Requirements
- R1: After a synchronous reset the status bits, mask bits, `irq_out`, `next_valid`, `next_bit`, `next_irq` and `bus_rdata` are all zero.
- R2: Input `irq_lines[i]` drives packed bit i. Bits 0 to 10 stand for legacy IRQs 3, 4, 5, 6, 7, 10, 11, 12, 9, 14 and 15 in that order. IRQs 0, 1, 2, 8 and 13 are never reported.
- R3: A rising edge on a line sets its status bit on the third clock edge after the line changes. A line that stays high, or falls, does not set the bit again.
- R4: Offset 0 reads packed bits 7..0 of status. Offset 1 reads packed bits 10..8 in data bits 2..0, and its upper five bits read zero.
- R5: A status write clears every bit written as one and leaves bits written as zero. A write to offset 0 acts on packed bits 7..0. A write to offset 1 acts on packed bits 10..8, taken from data bits 2..0.
- R6: When a rising edge sets a bit in the same cycle that a write clears it, the bit stays set.
- R7: Offset 2 holds mask bits 7..0 and offset 3 holds mask bits 10..8 in data bits 2..0. Both are read/write. A source is pending only when its status bit and its mask bit are both one.
- R8: `irq_out` is one exactly when the pending set was non-zero on the previous clock edge.
- R9: `next_bit` is the lowest-numbered pending packed bit and `next_irq` is its legacy IRQ number. Both are registered like `irq_out`. With nothing pending, `next_valid`, `next_bit` and `next_irq` are zero.
- R10: Offset 4 reads the fixed version byte (default 8'h21), and writes there change nothing. Offsets 5 to 7 read zero.
- R11: `bus_rdata` is registered: it shows the register at the `bus_addr` sampled on the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | 11 | Asynchronous legacy interrupt lines, index = packed bit |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq_out | output | 1 | Summary interrupt |
| next_valid | output | 1 | A source is pending |
| next_bit | output | 4 | Packed index of the source to service next |
| next_irq | output | 4 | Legacy IRQ number of that source |

## Verification
The assertions check on every cycle that an edge always lands in status and that no status bit appears without an edge. They also check that a clear with no competing edge takes effect. The picked index is checked to be the lowest pending bit, and the version offset is checked to read its fixed value. Other behaviour needs the bench's scenarios. These include the synchroniser latency and a level held high after a clear. They also include the collision of an edge with a clear in the same cycle, and cases where packed order and IRQ order disagree, such as IRQ 9 against IRQ 10.

// File: rtl/isa_irq_pkg.sv
package isa_irq_pkg;
  localparam int NUM_SRC  = 11;
  localparam int BYTE_W   = 8;
  localparam int HI_W     = NUM_SRC - BYTE_W;
  localparam int IDX_W    = $clog2(NUM_SRC);
  localparam int IRQNUM_W = 4;
  localparam int ADDR_W   = 3;

  typedef enum logic [ADDR_W-1:0] {
    OFS_STAT_LO = 3'd0,
    OFS_STAT_HI = 3'd1,
    OFS_MASK_LO = 3'd2,
    OFS_MASK_HI = 3'd3,
    OFS_VERSION = 3'd4
  } reg_ofs_e;

  // Packed bit to legacy IRQ number.
  function automatic logic [IRQNUM_W-1:0] bit_to_irq(input logic [IDX_W-1:0] b);
    case (b)
      4'd0:    return 4'd3;
      4'd1:    return 4'd4;
      4'd2:    return 4'd5;
      4'd3:    return 4'd6;
      4'd4:    return 4'd7;
      4'd5:    return 4'd10;
      4'd6:    return 4'd11;
      4'd7:    return 4'd12;
      4'd8:    return 4'd9;
      4'd9:    return 4'd14;
      4'd10:   return 4'd15;
      default: return 4'd0;
    endcase
  endfunction

  // Used by checks: idx is set in p and no lower bit of p is set.
  function automatic logic is_lowest(input logic [NUM_SRC-1:0] p, input logic [IDX_W-1:0] idx);
    logic [NUM_SRC-1:0] below;
    below = (NUM_SRC'(1) << idx) - NUM_SRC'(1);
    return p[idx] && ((p & below) == '0);
  endfunction
endpackage

// File: rtl/isa_irq_edge_sync.sv
module isa_irq_edge_sync #(
  parameter int N      = 11,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lines_i,
  output logic [N-1:0] rise_o
);
  for (genvar g = 0; g < N; g++) begin : g_line
    logic [STAGES:0] shift_q;
    always_ff @(posedge clk) begin
      if (rst) shift_q <= '0;
      else     shift_q <= {shift_q[STAGES-1:0], lines_i[g]};
    end
    assign rise_o[g] = shift_q[STAGES-1] & ~shift_q[STAGES];
  end
endmodule

// File: rtl/isa_irq_status.sv
module isa_irq_status #(
  parameter int N = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] status_o
);
  logic [N-1:0] status_q;

  always_ff @(posedge clk) begin
    if (rst) status_q <= '0;
    else     status_q <= (status_q & ~clr_i) | set_i;
  end
  assign status_o = status_q;

  AST_EDGE_LATCHES: assert property (@(posedge clk) disable iff (rst)
    (set_i != '0) |=> ((status_o & $past(set_i)) == $past(set_i))); // R3
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (rst)
    (set_i == '0) |=> ((status_o & ~$past(status_o)) == '0)); // R3
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
    ((clr_i & ~set_i) != '0) |=> ((status_o & $past(clr_i & ~set_i)) == '0)); // R5
endmodule

// File: rtl/isa_irq_pick.sv
module isa_irq_pick
  import isa_irq_pkg::*;
#(
  parameter int N = NUM_SRC
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N-1:0]        pend_i,
  output logic                any_o,
  output logic [IDX_W-1:0]    bit_o,
  output logic [IRQNUM_W-1:0] irq_o
);
  logic [IDX_W-1:0] low_idx;

  always_comb begin
    low_idx = '0;
    for (int i = N-1; i >= 0; i--)
      if (pend_i[i]) low_idx = IDX_W'(i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      any_o <= 1'b0;
      bit_o <= '0;
      irq_o <= '0;
    end else begin
      any_o <= |pend_i;
      bit_o <= low_idx;
      irq_o <= (|pend_i) ? bit_to_irq(low_idx) : '0;
    end
  end

  AST_PICK_LOWEST: assert property (@(posedge clk) disable iff (rst)
    any_o |-> is_lowest($past(pend_i), bit_o)); // R9
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !any_o |-> (bit_o == '0 && irq_o == '0)); // R9
  AST_IRQ_NONZERO: assert property (@(posedge clk) disable iff (rst)
    any_o |-> (irq_o >= 4'd3 && irq_o != 4'd8 && irq_o != 4'd13)); // R2
endmodule

// File: rtl/isa_irq_aggregator.sv
module isa_irq_aggregator
  import isa_irq_pkg::*;
#(
  parameter logic [7:0] VERSION = 8'h21
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_SRC-1:0]  irq_lines,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic [BYTE_W-1:0]   bus_wdata,
  output logic [BYTE_W-1:0]   bus_rdata,
  output logic                irq_out,
  output logic                next_valid,
  output logic [IDX_W-1:0]    next_bit,
  output logic [IRQNUM_W-1:0] next_irq
);
  logic [NUM_SRC-1:0] rise;
  logic [NUM_SRC-1:0] clr;
  logic [NUM_SRC-1:0] status;
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] pending;

  isa_irq_edge_sync #(.N(NUM_SRC), .STAGES(2)) i_sync (
    .clk(clk), .rst(rst), .lines_i(irq_lines), .rise_o(rise)
  );

  always_comb begin
    clr = '0;
    if (bus_wr && bus_addr == OFS_STAT_LO) clr[BYTE_W-1:0]       = bus_wdata;
    if (bus_wr && bus_addr == OFS_STAT_HI) clr[NUM_SRC-1:BYTE_W] = bus_wdata[HI_W-1:0];
  end

  isa_irq_status #(.N(NUM_SRC)) i_status (
    .clk(clk), .rst(rst), .set_i(rise), .clr_i(clr), .status_o(status)
  );

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else if (bus_wr) begin
      if (bus_addr == OFS_MASK_LO) mask_q[BYTE_W-1:0]       <= bus_wdata;
      if (bus_addr == OFS_MASK_HI) mask_q[NUM_SRC-1:BYTE_W] <= bus_wdata[HI_W-1:0];
    end
  end

  assign pending = status & mask_q;

  isa_irq_pick #(.N(NUM_SRC)) i_pick (
    .clk(clk), .rst(rst), .pend_i(pending),
    .any_o(next_valid), .bit_o(next_bit), .irq_o(next_irq)
  );
  assign irq_out = next_valid;

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else begin
      case (bus_addr)
        OFS_STAT_LO: bus_rdata <= status[BYTE_W-1:0];
        OFS_STAT_HI: bus_rdata <= BYTE_W'(status[NUM_SRC-1:BYTE_W]);
        OFS_MASK_LO: bus_rdata <= mask_q[BYTE_W-1:0];
        OFS_MASK_HI: bus_rdata <= BYTE_W'(mask_q[NUM_SRC-1:BYTE_W]);
        OFS_VERSION: bus_rdata <= VERSION;
        default:     bus_rdata <= '0;
      endcase
    end
  end

  AST_VERSION_FIXED: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == OFS_VERSION) |=> (bus_rdata == VERSION)); // R10
  AST_HI_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == OFS_STAT_HI) |=> (bus_rdata[7:HI_W] == '0)); // R4
  AST_MASK_GATES: assert property (@(posedge clk) disable iff (rst)
    ((status & mask_q) == '0) |=> !irq_out); // R7
endmodule

// File: tb/test_isa_irq_aggregator.sv
module test_isa_irq_aggregator;
  logic        clk = 1'b0;
  logic        rst;
  logic [10:0] irq_lines;
  logic [2:0]  bus_addr;
  logic        bus_wr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic        irq_out, next_valid;
  logic [3:0]  next_bit, next_irq;

  int checks = 0;
  int errors = 0;
  logic [10:0] m_stat = '0;
  logic [10:0] m_mask = '0;

  always #5 clk = ~clk;

  isa_irq_aggregator i_isa_irq_aggregator (
    .clk(clk), .rst(rst), .irq_lines(irq_lines), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out), .next_valid(next_valid), .next_bit(next_bit),
    .next_irq(next_irq)
  );

  function automatic int exp_irq(int b);
    int tbl [11] = '{3, 4, 5, 6, 7, 10, 11, 12, 9, 14, 15};
    return tbl[b];
  endfunction

  function automatic int exp_low(logic [10:0] p);
    for (int i = 0; i < 11; i++) if (p[i]) return i;
    return 0;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic drive(logic [10:0] v);
    m_stat |= v & ~irq_lines;
    irq_lines = v;
    wait_n(5);
  endtask

  task automatic check_all(string req);
    logic [10:0] p;
    logic [7:0]  d;
    p = m_stat & m_mask;
    check({req, " irq_out"}, irq_out, (p != 0));
    check({req, " next_valid"}, next_valid, (p != 0));
    check({req, " next_bit"}, next_bit, (p != 0) ? exp_low(p) : 0);
    check({req, " next_irq"}, next_irq, (p != 0) ? exp_irq(exp_low(p)) : 0);
    rd(3'd0, d); check({req, " R4 stat lo"}, d, m_stat[7:0]);
    rd(3'd1, d); check({req, " R4 stat hi"}, d, {5'b0, m_stat[10:8]});
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd1234));
    rst = 1'b1; irq_lines = '0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
    wait_n(3);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 irq_out", irq_out, 0);
    check("R1 next_irq", next_irq, 0);
    check("R1 rdata", bus_rdata, 0);
    rd(3'd2, d); check("R1 mask lo", d, 0);
    check_all("R1");

    // R10 version and unmapped offsets
    rd(3'd4, d); check("R10 version", d, 8'h21);
    wr(3'd4, 8'h00); rd(3'd4, d); check("R10 version after write", d, 8'h21);
    rd(3'd6, d); check("R10 unmapped", d, 0);

    // R11 registered read: data follows address one edge later
    bus_addr = 3'd4; @(posedge clk); #1 bus_addr = 3'd6;
    @(negedge clk); check("R11 first", bus_rdata, 8'h21);
    @(negedge clk); check("R11 second", bus_rdata, 0);

    // R7 mask registers
    wr(3'd2, 8'hFF); wr(3'd3, 8'hFF); m_mask = 11'h7FF;
    rd(3'd3, d); check("R7 mask hi", d, 8'h07);
    rd(3'd2, d); check("R7 mask lo", d, 8'hFF);

    // R3 latency: third edge after change
    irq_lines[2] = 1'b1;
    @(negedge clk); @(negedge clk);
    bus_addr = 3'd0; @(negedge clk);
    check("R3 not yet at edge 2", bus_rdata[2], 0);
    @(negedge clk);
    check("R3 set after edge 3", bus_rdata[2], 1);
    m_stat[2] = 1'b1;
    wait_n(2);
    check_all("R3");

    // R5 clear while line held high: no re-set
    wr(3'd0, 8'h04); m_stat[2] = 1'b0; wait_n(4);
    check_all("R5 clear held line");
    drive(11'h000);
    check_all("R3 fall");

    // R9/R2 packed order beats IRQ order: bit 5 (IRQ10) vs bit 8 (IRQ9)
    drive(11'h120);
    check("R9 bit", next_bit, 5);
    check("R2 irq", next_irq, 10);
    wr(3'd0, 8'h20); m_stat[5] = 1'b0; wait_n(3);
    check("R9 next bit 8", next_bit, 8);
    check("R2 irq 9", next_irq, 9);
    // R5 high byte clear uses shifted bit
    wr(3'd1, 8'h01); m_stat[8] = 1'b0; wait_n(3);
    check_all("R5 hi clear");
    drive(11'h000);

    // R6 edge coincides with clear: bit stays set
    drive(11'h010);
    drive(11'h000);
    irq_lines[4] = 1'b1;        // driven ahead of edge k
    @(negedge clk);             // after edge k
    bus_addr = 3'd0; bus_wdata = 8'h10; bus_wr = 1'b1; // write lands on edge k+2
    @(negedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
    wait_n(3);
    check_all("R6 collision");
    drive(11'h000);

    // R7 mask gating: masked pending hidden
    wr(3'd2, 8'h00); wr(3'd3, 8'h00); m_mask = '0; wait_n(3);
    check_all("R7 masked");
    wr(3'd3, 8'h04); m_mask[10] = 1'b1;
    drive(11'h400);
    check("R2 bit10 irq15", next_irq, 15);
    check_all("R8 pending");

    // random phase
    for (int it = 0; it < 300; it++) begin
      int op = $urandom_range(0, 3);
      case (op)
        0: drive(11'($urandom));
        1: begin
          logic [7:0] c = 8'($urandom);
          wr(3'd0, c); m_stat[7:0] &= ~c; wait_n(3);
        end
        2: begin
          logic [7:0] c = 8'($urandom);
          wr(3'd1, c); m_stat[10:8] &= ~c[2:0]; wait_n(3);
        end
        default: begin
          logic [7:0] c = 8'($urandom);
          if (c[0]) begin wr(3'd2, c); m_mask[7:0] = c; end
          else begin wr(3'd3, c); m_mask[10:8] = c[2:0]; end
          wait_n(3);
        end
      endcase
      check_all("R9 random");
    end

    // R1 reset again clears everything
    rst = 1'b1; wait_n(2); rst = 1'b0; irq_lines = '0; m_stat = '0; m_mask = '0;
    wait_n(4);
    check_all("R1 re-reset");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule